// File: doc/BRIEF.md
# Disk Interface Control Register Bank

This block is the control register file of a disk interface bridge. A 16-bit register port lets software hold an interrupt cause and mask pair, DMA and transfer control words, an interface control word and three drive timing words (PIO, multiword DMA and Ultra DMA). The interrupt request leaves the block as the AND of cause and mask, reduced to one bit.

Each timing word is decoded all the time into a mode number and a valid flag, so the transfer engine never sees an unsupported timing. The interface control word has two action bits. Bit 7 restores fixed defaults for the whole interface. Bit 6 is an active-low drive-run bit: writing it as 0 sends a one-cycle hard-reset pulse to the drive.

Writes that set bits with no defined meaning, and accesses that are not 16 bits wide, set sticky error flags. A write to the error word clears those flags. Word addresses: 0 cause, 1 mask, 2 DMA control, 3 transfer control, 4 interface control, 5 PIO timing, 6 multiword DMA timing, 7 Ultra DMA timing, 8 capabilities (read only), 9 error status (bit 0 unknown bits, bit 1 width). Reads of any other address return 0.

Top module: `disk_ifctl_regs`

## Requirements
- R1: `irq` is high exactly when the cause and mask registers share a set bit. `cause_set` ORs bits into the cause register. A 16-bit write to word 0 clears the cause bits written as 1, and a bit set in the same cycle stays set.
- R2: A mask write whose new value differs from the old one, where (old OR new) overlaps the cause register, gives a one-cycle `irq_retrigger` pulse in the cycle after the write. Any other mask write gives no pulse.
- R3: A write to word 4 with bit 7 set loads interface control 0x001A, PIO timing 0x0024, multiword DMA timing 0x0045 and Ultra DMA timing 0x0083, in place of the written value.
- R4: A write to word 4 with bit 6 at 0 drives `drive_reset` high for exactly the one cycle after the write. With bit 6 at 1 there is no pulse.
- R5: PIO timing codes 0x0092, 0x0072, 0x0032, 0x0024 and 0x0023 decode to modes 0 to 4 with `pio_valid` high. Every other 16-bit value gives `pio_valid` low and mode 0.
- R6: Multiword DMA codes 0x00FF, 0x0045 and 0x0024 decode to modes 0 to 2. Ultra DMA codes 0x00A7, 0x0085, 0x0063, 0x0062 and 0x0061 decode to modes 0 to 4. Any other value is invalid and gives mode 0.
- R7: `err_unknown_bits` is set by any of three writes: transfer control with a bit of 0xFF78 set, DMA control with a bit of 0xFFE8 set, or interface control with a nonzero upper byte. The written value is still stored.
- R8: An access with `bus_size` other than 2'b01 (2'b00 = 8-bit, 2'b10 = 32-bit, 2'b11 reserved) sets `err_width`, changes no register and reads 0.
- R9: Both error flags stay set until a 16-bit write to word 9. They read as 0 from the cycle after that write.
- R10: Word 8 reads bit 0 = `net_present`, bit 1 = `disk_present`, bit 5 = 1, and all other bits 0.
- R11: After reset, words 0 to 4 read 0 and the timing words hold the R3 defaults. `irq`, `drive_reset`, `irq_retrigger` and both error flags are low.
- R12: Words 1, 2, 3, 5, 6 and 7 read back the last 16-bit value written to them. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_size | input | 2 | Access width code, 2'b01 = 16-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| cause_set | input | 16 | Interrupt cause bits to set |
| net_present | input | 1 | Network interface fitted |
| disk_present | input | 1 | Disk fitted |
| irq | output | 1 | Masked interrupt request |
| irq_retrigger | output | 1 | Pulse after a mask change touching a pending cause |
| drive_reset | output | 1 | Drive hard-reset pulse |
| err_unknown_bits | output | 1 | Sticky undefined-bit write flag |
| err_width | output | 1 | Sticky bad-width access flag |
| pio_mode | output | 3 | Decoded PIO mode |
| pio_valid | output | 1 | PIO code recognised |
| mdma_mode | output | 3 | Decoded multiword DMA mode |
| mdma_valid | output | 1 | Multiword DMA code recognised |
| udma_mode | output | 3 | Decoded Ultra DMA mode |
| udma_valid | output | 1 | Ultra DMA code recognised |

## Verification
The assertions assume that `bus_wr`, `bus_rd` and `bus_size` hold known values from the first clock, and that a read and a write never happen in the same cycle. The bench drives every bus input to a defined idle value from time zero and changes inputs only on falling edges. The retrigger property also assumes `cause_set` is idle while the mask is written. The bench pulses cause bits well before its mask sweep and keeps them quiet during it.

// File: rtl/disk_ifctl_pkg.sv
package disk_ifctl_pkg;

  localparam int DW = 16;
  localparam int TIM_N = 3;

  typedef enum logic [1:0] {TIM_PIO = 2'd0, TIM_MDMA = 2'd1, TIM_UDMA = 2'd2} tim_kind_e;

  localparam int A_CAUSE = 0;
  localparam int A_MASK  = 1;
  localparam int A_DMA   = 2;
  localparam int A_XFR   = 3;
  localparam int A_IF    = 4;
  localparam int A_TIM0  = 5;
  localparam int A_CAPS  = 8;
  localparam int A_ERR   = 9;

  localparam logic [1:0] SZ_16 = 2'b01;

  localparam int IFB_IFRESET = 7;
  localparam int IFB_DRV_RUN = 6;

  localparam logic [DW-1:0] IF_DEFAULT = 16'h001A;
  localparam logic [DW-1:0] XFR_BAD    = 16'hFF78;
  localparam logic [DW-1:0] DMA_BAD    = 16'hFFE8;
  localparam logic [DW-1:0] IF_BAD     = 16'hFF00;

  typedef struct packed {
    logic       valid;
    logic [2:0] num;
  } tim_dec_t;

  function automatic logic [DW-1:0] tim_default(int idx);
    case (idx)
      0:       return 16'h0024;
      1:       return 16'h0045;
      default: return 16'h0083;
    endcase
  endfunction

  function automatic tim_dec_t tim_decode(tim_kind_e kind, logic [DW-1:0] code);
    tim_dec_t r;
    r = '0;
    case (kind)
      TIM_PIO:
        case (code)
          16'h0092: r = '{1'b1, 3'd0};
          16'h0072: r = '{1'b1, 3'd1};
          16'h0032: r = '{1'b1, 3'd2};
          16'h0024: r = '{1'b1, 3'd3};
          16'h0023: r = '{1'b1, 3'd4};
          default:  r = '0;
        endcase
      TIM_MDMA:
        case (code)
          16'h00FF: r = '{1'b1, 3'd0};
          16'h0045: r = '{1'b1, 3'd1};
          16'h0024: r = '{1'b1, 3'd2};
          default:  r = '0;
        endcase
      default:
        case (code)
          16'h00A7: r = '{1'b1, 3'd0};
          16'h0085: r = '{1'b1, 3'd1};
          16'h0063: r = '{1'b1, 3'd2};
          16'h0062: r = '{1'b1, 3'd3};
          16'h0061: r = '{1'b1, 3'd4};
          default:  r = '0;
        endcase
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] caps_word(logic net, logic disk);
    logic [DW-1:0] w;
    w = '0;
    w[0] = net;
    w[1] = disk;
    w[5] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/disk_ifctl_irq.sv
module disk_ifctl_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cause_set,
  input  logic         cause_clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause,
  output logic [W-1:0] mask,
  output logic         irq,
  output logic         retrigger
);

  logic [W-1:0] clr_bits;
  logic         mask_change_hit;

  assign clr_bits        = cause_clr_we ? wdata : '0;
  assign mask_change_hit = mask_we && (wdata != mask) && (|((mask | wdata) & cause));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause     <= '0;
      mask      <= '0;
      retrigger <= 1'b0;
    end else begin
      cause     <= (cause & ~clr_bits) | cause_set;
      if (mask_we) mask <= wdata;
      retrigger <= mask_change_hit;
    end
  end

  assign irq = |(cause & mask);

endmodule

// File: rtl/disk_ifctl_modedec.sv
module disk_ifctl_modedec
  import disk_ifctl_pkg::*;
#(
  parameter tim_kind_e KIND = TIM_PIO
) (
  input  logic [DW-1:0] code,
  output logic [2:0]    mode,
  output logic          valid
);

  tim_dec_t dec;

  always_comb begin
    dec   = tim_decode(KIND, code);
    mode  = dec.num;
    valid = dec.valid;
  end

endmodule

// File: rtl/disk_ifctl_errtrack.sv
module disk_ifctl_errtrack (
  input  logic clk,
  input  logic rst_n,
  input  logic unk_evt,
  input  logic width_evt,
  input  logic clr,
  output logic err_unk,
  output logic err_width
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_unk   <= 1'b0;
      err_width <= 1'b0;
    end else begin
      err_unk   <= unk_evt   | (err_unk   & ~clr);
      err_width <= width_evt | (err_width & ~clr);
    end
  end

endmodule

// File: rtl/disk_ifctl_regs.sv
module disk_ifctl_regs
  import disk_ifctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     cause_set,
  input  logic              net_present,
  input  logic              disk_present,
  output logic              irq,
  output logic              irq_retrigger,
  output logic              drive_reset,
  output logic              err_unknown_bits,
  output logic              err_width,
  output logic [2:0]        pio_mode,
  output logic              pio_valid,
  output logic [2:0]        mdma_mode,
  output logic              mdma_valid,
  output logic [2:0]        udma_mode,
  output logic              udma_valid
);

  localparam int NWORDS = 1 << ADDR_W;

  // access qualification, brought out as named events
  logic size_ok, wr_ok, rd_ok, width_evt;
  logic wr_cause, wr_mask, wr_dma, wr_xfr, wr_if, wr_err;
  logic if_reset_evt, drv_reset_evt, unk_evt;
  logic [TIM_N-1:0] wr_tim;

  assign size_ok   = (bus_size == SZ_16);
  assign wr_ok     = bus_wr & size_ok;
  assign rd_ok     = bus_rd & size_ok;
  assign width_evt = (bus_wr | bus_rd) & ~size_ok;

  assign wr_cause = wr_ok && (bus_addr == ADDR_W'(A_CAUSE));
  assign wr_mask  = wr_ok && (bus_addr == ADDR_W'(A_MASK));
  assign wr_dma   = wr_ok && (bus_addr == ADDR_W'(A_DMA));
  assign wr_xfr   = wr_ok && (bus_addr == ADDR_W'(A_XFR));
  assign wr_if    = wr_ok && (bus_addr == ADDR_W'(A_IF));
  assign wr_err   = wr_ok && (bus_addr == ADDR_W'(A_ERR));

  assign if_reset_evt  = wr_if &  bus_wdata[IFB_IFRESET];
  assign drv_reset_evt = wr_if & ~bus_wdata[IFB_DRV_RUN];
  assign unk_evt = (wr_xfr && |(bus_wdata & XFR_BAD))
                 | (wr_dma && |(bus_wdata & DMA_BAD))
                 | (wr_if  && |(bus_wdata & IF_BAD));

  // control and timing storage
  logic [DW-1:0] dma_q, xfr_q, if_q;
  logic [DW-1:0] tim_q [TIM_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_q       <= '0;
      xfr_q       <= '0;
      if_q        <= '0;
      drive_reset <= 1'b0;
      for (int i = 0; i < TIM_N; i++) tim_q[i] <= tim_default(i);
    end else begin
      drive_reset <= drv_reset_evt;
      if (wr_dma) dma_q <= bus_wdata;
      if (wr_xfr) xfr_q <= bus_wdata;
      for (int i = 0; i < TIM_N; i++)
        if (wr_tim[i]) tim_q[i] <= bus_wdata;
      if (if_reset_evt) begin
        if_q <= IF_DEFAULT;
        for (int i = 0; i < TIM_N; i++) tim_q[i] <= tim_default(i);
      end else if (wr_if) begin
        if_q <= bus_wdata;
      end
    end
  end

  // timing decoders, one per timing word
  logic [2:0]       dec_mode  [TIM_N];
  logic [TIM_N-1:0] dec_valid;

  for (genvar g = 0; g < TIM_N; g++) begin : g_tim
    assign wr_tim[g] = wr_ok && (bus_addr == ADDR_W'(A_TIM0 + g));
    disk_ifctl_modedec #(.KIND(tim_kind_e'(g))) i_dec (
      .code  (tim_q[g]),
      .mode  (dec_mode[g]),
      .valid (dec_valid[g])
    );
  end

  assign pio_mode   = dec_mode[0];
  assign pio_valid  = dec_valid[0];
  assign mdma_mode  = dec_mode[1];
  assign mdma_valid = dec_valid[1];
  assign udma_mode  = dec_mode[2];
  assign udma_valid = dec_valid[2];

  // interrupt cause and mask
  logic [DW-1:0] cause_q, mask_q;

  disk_ifctl_irq #(.W(DW)) i_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cause_set    (cause_set),
    .cause_clr_we (wr_cause),
    .mask_we      (wr_mask),
    .wdata        (bus_wdata),
    .cause        (cause_q),
    .mask         (mask_q),
    .irq          (irq),
    .retrigger    (irq_retrigger)
  );

  // sticky error flags
  disk_ifctl_errtrack i_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .unk_evt   (unk_evt),
    .width_evt (width_evt),
    .clr       (wr_err),
    .err_unk   (err_unknown_bits),
    .err_width (err_width)
  );

  // read mux
  logic [DW-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (int'(bus_addr) < NWORDS) begin
      case (int'(bus_addr))
        A_CAUSE:    rd_word = cause_q;
        A_MASK:     rd_word = mask_q;
        A_DMA:      rd_word = dma_q;
        A_XFR:      rd_word = xfr_q;
        A_IF:       rd_word = if_q;
        A_TIM0:     rd_word = tim_q[0];
        A_TIM0 + 1: rd_word = tim_q[1];
        A_TIM0 + 2: rd_word = tim_q[2];
        A_CAPS:     rd_word = caps_word(net_present, disk_present);
        A_ERR:      rd_word = {{(DW-2){1'b0}}, err_width, err_unknown_bits};
        default:    rd_word = '0;
      endcase
    end
  end

  assign bus_rdata = rd_ok ? rd_word : '0;

endmodule

// File: rtl/disk_ifctl_regs_chk.sv
module disk_ifctl_regs_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [15:0]       bus_wdata,
  input logic              irq,
  input logic              irq_retrigger,
  input logic              drive_reset,
  input logic              err_width,
  input logic [2:0]        pio_mode,
  input logic              pio_valid,
  input logic [2:0]        mdma_mode,
  input logic              mdma_valid,
  input logic              udma_valid
);

  logic ok16, w_mask, w_if, w_pio, w_err;
  assign ok16   = (bus_size == 2'b01);
  assign w_mask = bus_wr && ok16 && (bus_addr == ADDR_W'(1));
  assign w_if   = bus_wr && ok16 && (bus_addr == ADDR_W'(4));
  assign w_pio  = bus_wr && ok16 && (bus_addr == ADDR_W'(5));
  assign w_err  = bus_wr && ok16 && (bus_addr == ADDR_W'(9));

  // R1: a cleared mask silences the request
  assert_mask_zero_quiets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (w_mask && bus_wdata == 16'h0) |=> !irq);

  // R2: a retrigger pulse always follows a mask write
  assert_retrigger_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_retrigger |-> $past(w_mask));

  // R3: interface reset restores timing defaults
  assert_ifreset_defaults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_if && bus_wdata[7]) |=> (pio_valid && pio_mode == 3'd3 && mdma_valid && mdma_mode == 3'd1 && !udma_valid));

  // R4: drive reset pulse only after a write with the run bit low
  assert_drive_reset_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_reset |-> $past(w_if && !bus_wdata[6]));

  assert_drive_reset_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_if && !bus_wdata[6]) |=> drive_reset);

  // R5: a mode-4 PIO code decodes to mode 4
  assert_pio_top_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_pio && bus_wdata == 16'h0023) |=> (pio_valid && pio_mode == 3'd4));

  // R8: a bad access width raises the width flag
  assert_width_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !ok16) |=> err_width);

  // R9: the width flag holds until cleared
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_width && !w_err) |=> err_width);

endmodule

bind disk_ifctl_regs disk_ifctl_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_addr      (bus_addr),
  .bus_size      (bus_size),
  .bus_wdata     (bus_wdata),
  .irq           (irq),
  .irq_retrigger (irq_retrigger),
  .drive_reset   (drive_reset),
  .err_width     (err_width),
  .pio_mode      (pio_mode),
  .pio_valid     (pio_valid),
  .mdma_mode     (mdma_mode),
  .mdma_valid    (mdma_valid),
  .udma_valid    (udma_valid)
);

// File: tb/test_disk_ifctl_regs.sv
`timescale 1ns/1ps
module test_disk_ifctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [1:0]  bus_size = 2'b01;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [15:0] cause_set = 16'h0;
  logic        net_present = 1'b0;
  logic        disk_present = 1'b0;
  logic        irq, irq_retrigger, drive_reset, err_unknown_bits, err_width;
  logic [2:0]  pio_mode, mdma_mode, udma_mode;
  logic        pio_valid, mdma_valid, udma_valid;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  disk_ifctl_regs #(.ADDR_W(4)) i_disk_ifctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cause_set(cause_set),
    .net_present(net_present), .disk_present(disk_present),
    .irq(irq), .irq_retrigger(irq_retrigger), .drive_reset(drive_reset),
    .err_unknown_bits(err_unknown_bits), .err_width(err_width),
    .pio_mode(pio_mode), .pio_valid(pio_valid),
    .mdma_mode(mdma_mode), .mdma_valid(mdma_valid),
    .udma_mode(udma_mode), .udma_valid(udma_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] sz = 2'b01);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 2'b01;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d, input logic [1:0] sz = 2'b01);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_size = 2'b01;
  endtask

  // expected decode: position of the code in its list, computed by search
  function automatic logic [3:0] exp_dec(input int kind, input logic [15:0] code);
    logic [7:0] lst [5];
    int n;
    if (kind == 0) begin lst = '{8'h92, 8'h72, 8'h32, 8'h24, 8'h23}; n = 5; end
    else if (kind == 1) begin lst = '{8'hFF, 8'h45, 8'h24, 8'h00, 8'h00}; n = 3; end
    else begin lst = '{8'hA7, 8'h85, 8'h63, 8'h62, 8'h61}; n = 5; end
    for (int i = 0; i < n; i++)
      if (code == {8'h00, lst[i]}) return {1'b1, 3'(i)};
    return 4'h0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] old_mask;
    logic [15:0] cause_model;
    logic [15:0] v;
    logic        exp_err;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(4'd0, d); chk("R11 cause", d, 16'h0);
    rd(4'd1, d); chk("R11 mask", d, 16'h0);
    rd(4'd2, d); chk("R11 dma", d, 16'h0);
    rd(4'd3, d); chk("R11 xfr", d, 16'h0);
    rd(4'd4, d); chk("R11 ifctl", d, 16'h0);
    rd(4'd5, d); chk("R11 pio", d, 16'h0024);
    rd(4'd6, d); chk("R11 mdma", d, 16'h0045);
    rd(4'd7, d); chk("R11 udma", d, 16'h0083);
    chk("R11 outs", {irq, irq_retrigger, drive_reset, err_unknown_bits, err_width}, 0);
    chk("R11 decode", {pio_valid, pio_mode, mdma_valid, mdma_mode, udma_valid}, {1'b1, 3'd3, 1'b1, 3'd1, 1'b0});

    // R10 capabilities over all fitted combinations
    for (int k = 0; k < 4; k++) begin
      net_present = k[0]; disk_present = k[1];
      rd(4'd8, d);
      chk("R10 caps", d, 16'h0020 + 16'(k[0]) + 16'(2 * k[1]));
    end

    // R12 readback and unmapped reads
    for (int k = 0; k < 8; k++) begin
      if (k == 0 || k == 4) continue;
      v = 16'h0011 * 16'(k + 1) ^ 16'h0500;
      wr(4'(k), v);
      rd(4'(k), d);
      chk("R12 readback", d, v);
    end
    for (int k = 10; k < 16; k++) begin
      rd(4'(k), d);
      chk("R12 unmapped", d, 16'h0);
    end
    wr(4'd9, 16'h0);

    // R5 R6 timing decode sweep over every low-byte code plus upper-byte probes
    for (int kind = 0; kind < 3; kind++) begin
      for (int c = 0; c < 260; c++) begin
        v = (c < 256) ? 16'(c) : (16'h0100 << (c - 256)) | 16'h0024;
        wr(4'(5 + kind), v);
        if (kind == 0) chk("R5 pio decode", {pio_valid, pio_mode}, exp_dec(0, v));
        else if (kind == 1) chk("R6 mdma decode", {mdma_valid, mdma_mode}, exp_dec(1, v));
        else chk("R6 udma decode", {udma_valid, udma_mode}, exp_dec(2, v));
      end
    end

    // R1 R2 cause, mask and retrigger
    wr(4'd1, 16'h0000);
    @(negedge clk); cause_set = 16'h0005;
    @(negedge clk); cause_set = 16'h0000;
    cause_model = 16'h0005;
    rd(4'd0, d); chk("R1 cause set", d, cause_model);
    chk("R1 irq with zero mask", irq, 1'b0);
    old_mask = 16'h0000;
    for (int b = 0; b < 16; b++) begin
      v = 16'h1 << b;
      wr(4'd1, v);
      chk("R2 retrigger", irq_retrigger, (v != old_mask) && (((v | old_mask) & cause_model) != 0));
      chk("R1 irq", irq, (v & cause_model) != 0);
      old_mask = v;
    end
    wr(4'd1, old_mask);
    chk("R2 unchanged mask no pulse", irq_retrigger, 1'b0);
    wr(4'd1, 16'h0004);
    chk("R2 pulse on overlap", irq_retrigger, 1'b1);
    @(negedge clk);
    chk("R2 pulse one cycle", irq_retrigger, 1'b0);
    wr(4'd0, 16'h0001);
    cause_model = 16'h0004;
    rd(4'd0, d); chk("R1 w1c partial", d, cause_model);
    chk("R1 irq still", irq, 1'b1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 16'h0004; cause_set = 16'h0004;
    @(negedge clk);
    bus_wr = 1'b0; cause_set = 16'h0;
    rd(4'd0, d); chk("R1 set beats clear", d, 16'h0004);
    wr(4'd0, 16'h0004);
    rd(4'd0, d); chk("R1 w1c full", d, 16'h0);
    chk("R1 irq low", irq, 1'b0);

    // R7 R9 unknown-bit flags, one bit at a time
    for (int b = 0; b < 16; b++) begin
      v = 16'h1 << b;
      wr(4'd3, v);
      exp_err = (v & 16'hFF78) != 0;
      chk("R7 xfr flag", err_unknown_bits, exp_err);
      rd(4'd3, d); chk("R7 xfr stored", d, v);
      wr(4'd9, 16'h0);
      chk("R9 clear", err_unknown_bits, 1'b0);
      wr(4'd2, v);
      chk("R7 dma flag", err_unknown_bits, (v & 16'hFFE8) != 0);
      wr(4'd9, 16'h0);
      wr(4'd4, v | 16'h0040);
      chk("R7 if flag", err_unknown_bits, b >= 8);
      wr(4'd9, 16'h0);
    end
    wr(4'd3, 16'h8000);
    repeat (5) @(negedge clk);
    chk("R9 unknown sticky", err_unknown_bits, 1'b1);
    rd(4'd9, d); chk("R9 status word", d, 16'h0001);
    wr(4'd9, 16'h0);

    // R4 drive reset pulse
    wr(4'd4, 16'h0000);
    chk("R4 pulse high", drive_reset, 1'b1);
    @(negedge clk);
    chk("R4 pulse one cycle", drive_reset, 1'b0);
    wr(4'd4, 16'h0040);
    chk("R4 no pulse with run bit", drive_reset, 1'b0);
    rd(4'd4, d); chk("R4 if stored", d, 16'h0040);

    // R3 interface reset
    wr(4'd5, 16'h0092); wr(4'd6, 16'h00FF); wr(4'd7, 16'h0061);
    wr(4'd4, 16'h00C0);
    chk("R3 no drive pulse", drive_reset, 1'b0);
    rd(4'd4, d); chk("R3 if default", d, 16'h001A);
    rd(4'd5, d); chk("R3 pio default", d, 16'h0024);
    rd(4'd6, d); chk("R3 mdma default", d, 16'h0045);
    rd(4'd7, d); chk("R3 udma default", d, 16'h0083);
    wr(4'd4, 16'h0080);
    chk("R3 with drive pulse", drive_reset, 1'b1);
    rd(4'd4, d); chk("R3 if default again", d, 16'h001A);

    // R8 R9 width errors
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      wr(4'd1, 16'hFFFF, 2'(s));
      chk("R8 width flag write", err_width, 1'b1);
      rd(4'd1, d); chk("R8 write ignored", d, 16'h0004);
      wr(4'd9, 16'h0);
      chk("R9 width cleared", err_width, 1'b0);
      rd(4'd8, d, 2'(s));
      chk("R8 bad read zero", d, 16'h0);
      chk("R8 width flag read", err_width, 1'b1);
      repeat (4) @(negedge clk);
      chk("R9 width sticky", err_width, 1'b1);
      wr(4'd9, 16'h0);
    end
    rd(4'd9, d); chk("R9 status clear", d, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule